// File: doc/BRIEF.md
# DRAM Channel Interleave Router

This block takes a physical system address and decides which of up to four DRAM controller channels owns it. It checks the address against a programmed channel range and against a memory-mapped I/O hole below 4 GB. It then selects a channel, either from a fixed configuration field or from low address bits when channels are interleaved. Finally it produces the channel-local address.

The channel-local address is formed in three steps. A normalization offset is subtracted first. The interleave select bits are then removed, and an optional per-channel high offset is added. Each lookup is presented with `in_valid`, and the result appears on registered outputs one clock later. A rejected lookup carries an error flag and a 2-bit reason code, and its channel and address outputs are zero.

Top module: `dram_chan_router`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle in which `in_valid` was sampled high, and low otherwise. While `rst` is high, `out_valid` and `out_err` read 0.
- R2: The channel range spans from `rng_base`·2^27 up to `rng_limit`·2^27 + 2^27−1, with both ends included. When `rng_chk_off` is 0, an address outside this span is rejected with code 0 (out of range). When `rng_chk_off` is 1, the range check is skipped.
- R3: When `hole_vld` is 1, an address below 2^32 whose bits [31:24] are at or above `hole_base` is rejected with code 1 (in hole).
- R4: If `ilv_mask` has an odd number of ones, the lookup is rejected with code 2 (bad interleave configuration). Zero ones means interleaving is off.
- R5: The interleave mode is {`mode_hi`, `mode_lo`}. When two or four channels are interleaved and the mode is neither 4 nor 5, the lookup is rejected with code 3 (bad mode).
- R6: When several reasons apply, the reported code is the one that comes first in this order: out of range, in hole, bad configuration, bad mode. On any error, `out_chan` and `out_addr` are 0.
- R7: With interleaving off, `out_chan` equals `chan_sel`, and no address bits are removed.
- R8: With two channels interleaved, address bit 8 (mode 4) or bit 9 (mode 5) selects the channel: 1 gives channel 3 and 0 gives channel 0.
- R9: With four channels interleaved, address bits [9:8] (mode 4) or [10:9] (mode 5) give the channel number directly.
- R10: The offset subtracted from the address, modulo 2^48, depends on `hole_remap` and the address. When `hole_remap` is 1 and the address is at or above 2^32, the offset is `hole_ofs`·2^24. Otherwise it is `rng_base`·2^27.
- R11: After the subtraction, interleave bits are removed. The low 8 bits (mode 4) or low 9 bits (mode 5) are kept. The bits above them are shifted down by one position (two channels) or two positions (four channels).
- R12: When `hoff_en` is 1, the 12-bit field `hoff_flat`[12i+11:12i] is added, shifted left by 27, modulo 2^48. The index i is the low two bits of the selected channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Lookup request |
| sys_addr | input | 48 | System address to route |
| rng_chk_off | input | 1 | Skip the channel range check |
| rng_base | input | 13 | Range base, units of 2^27 |
| rng_limit | input | 13 | Range limit, units of 2^27 |
| chan_sel | input | 3 | Channel used when interleaving is off |
| ilv_mask | input | 4 | Interleave enable mask |
| mode_hi | input | 1 | Top bit of the interleave mode |
| mode_lo | input | 2 | Low bits of the interleave mode |
| hole_vld | input | 1 | I/O hole present |
| hole_base | input | 8 | Hole start, address bits [31:24] |
| hole_remap | input | 1 | Use the hoist offset above 4 GB |
| hole_ofs | input | 16 | Hoist offset, units of 2^24 |
| hoff_en | input | 1 | Add the per-channel high offset |
| hoff_flat | input | 48 | Four 12-bit high offsets, channel 0 lowest |
| out_valid | output | 1 | Result strobe |
| out_err | output | 1 | Lookup rejected |
| out_code | output | 2 | Reject reason |
| out_chan | output | 3 | Selected channel |
| out_addr | output | 48 | Channel-local address |

## Verification
The assertions assume three things: `in_valid` stays low while `rst` is high, every configuration input is a known value in any cycle where `in_valid` is high, and the configuration is sampled together with the address in that cycle. The bench drives all inputs on the falling edge and holds `in_valid` low through reset. Its stimulus draws configurations mostly from legal masks and modes, and it places addresses both inside and outside the range and the hole. This makes every reject reason, and every overlap between them, occur.

// File: rtl/dcr_pkg.sv
`timescale 1ns/1ps
package dcr_pkg;
    localparam int ADDR_W   = 48;
    localparam int CHANS    = 4;
    localparam int CHAN_W   = 3;
    localparam int SEL_W    = $clog2(CHANS);
    localparam int RNG_W    = 13;
    localparam int RNG_SH   = 27;
    localparam int HOFF_W   = 12;
    localparam int HOLE_W   = 8;
    localparam int HOLE_SH  = 24;
    localparam int HOFS_W   = 16;
    localparam int LOW4G_W  = 32;
    localparam int MODE_W   = 3;

    typedef enum logic [1:0] {
        ERR_RANGE = 2'd0,
        ERR_HOLE  = 2'd1,
        ERR_CFG   = 2'd2,
        ERR_MODE  = 2'd3
    } err_e;

    typedef enum logic [1:0] {
        WAYS_1 = 2'd0,
        WAYS_2 = 2'd1,
        WAYS_4 = 2'd2
    } ways_e;

    typedef struct packed {
        logic              err;
        err_e              code;
        logic [CHAN_W-1:0] chan;
        logic [ADDR_W-1:0] addr;
    } route_t;

    // Remove the interleave select bits: keep the low 8 or 9 bits and
    // pull the remainder down by the number of select bits.
    function automatic logic [ADDR_W-1:0] squeeze(
        input logic [ADDR_W-1:0] a,
        input logic              on9,
        input ways_e             w
    );
        int                keep;
        int                drop;
        logic [ADDR_W-1:0] low_m;
        logic [ADDR_W-1:0] up;
        keep  = on9 ? 9 : 8;
        drop  = (w == WAYS_4) ? 2 : 1;
        low_m = (ADDR_W'(1) << keep) - ADDR_W'(1);
        up    = (a >> (keep + drop)) << keep;
        if (w == WAYS_1) return a;
        return up | (a & low_m);
    endfunction
endpackage

// File: rtl/dcr_chan_pick.sv
`timescale 1ns/1ps
module dcr_chan_pick
    import dcr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [CHANS-1:0]  mask,
    input  logic [MODE_W-1:0] mode,
    input  logic [CHAN_W-1:0] fixed_sel,
    output ways_e             ways,
    output logic              cfg_err,
    output logic              mode_err,
    output logic              on9,
    output logic [CHAN_W-1:0] chan
);
    logic [$clog2(CHANS+1)-1:0] n_on;
    logic [SEL_W-1:0]           sel_bits;

    always_comb begin
        n_on = '0;
        for (int i = 0; i < CHANS; i++) n_on = n_on + {{($bits(n_on)-1){1'b0}}, mask[i]};
    end

    always_comb begin
        cfg_err = 1'b0;
        unique case (n_on)
            0:       ways = WAYS_1;
            2:       ways = WAYS_2;
            4:       ways = WAYS_4;
            default: begin ways = WAYS_1; cfg_err = 1'b1; end
        endcase
    end

    assign on9      = mode[0];
    assign mode_err = !cfg_err && (ways != WAYS_1) &&
                      !(mode == MODE_W'(4) || mode == MODE_W'(5));
    assign sel_bits = on9 ? addr[9 +: SEL_W] : addr[8 +: SEL_W];

    always_comb begin
        unique case (ways)
            WAYS_2:  chan = sel_bits[0] ? CHAN_W'(CHANS-1) : '0;
            WAYS_4:  chan = CHAN_W'(sel_bits);
            default: chan = fixed_sel;
        endcase
    end
endmodule

// File: rtl/dcr_addr_norm.sv
`timescale 1ns/1ps
module dcr_addr_norm
    import dcr_pkg::*;
(
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     chk_off,
    input  logic [RNG_W-1:0]         base_f,
    input  logic [RNG_W-1:0]         limit_f,
    input  logic                     hole_vld,
    input  logic [HOLE_W-1:0]        hole_base,
    input  logic                     hole_remap,
    input  logic [HOFS_W-1:0]        hole_ofs,
    input  logic                     hoff_en,
    input  logic [CHANS*HOFF_W-1:0]  hoff_flat,
    input  logic [CHAN_W-1:0]        chan,
    input  ways_e                    ways,
    input  logic                     on9,
    output logic                     range_err,
    output logic                     hole_err,
    output logic [ADDR_W-1:0]        norm
);
    logic [HOFF_W-1:0] hoff [CHANS];
    logic [ADDR_W-1:0] lo_b, hi_b, ofs, diff, sq, add;
    logic              above4g;

    for (genvar g = 0; g < CHANS; g++) begin : g_hoff
        assign hoff[g] = hoff_flat[g*HOFF_W +: HOFF_W];
    end

    assign lo_b    = ADDR_W'(base_f) << RNG_SH;
    assign hi_b    = (ADDR_W'(limit_f) << RNG_SH) | ((ADDR_W'(1) << RNG_SH) - ADDR_W'(1));
    assign above4g = |addr[ADDR_W-1:LOW4G_W];

    assign range_err = !chk_off && ((addr < lo_b) || (addr > hi_b));
    assign hole_err  = hole_vld && !above4g &&
                       (addr[LOW4G_W-1:HOLE_SH] >= hole_base);

    assign ofs  = (hole_remap && above4g) ? (ADDR_W'(hole_ofs) << HOLE_SH) : lo_b;
    assign diff = addr - ofs;
    assign sq   = squeeze(diff, on9, ways);
    assign add  = hoff_en ? (ADDR_W'(hoff[chan[SEL_W-1:0]]) << RNG_SH) : '0;
    assign norm = sq + add;
endmodule

// File: rtl/dram_chan_router.sv
`timescale 1ns/1ps
module dram_chan_router
    import dcr_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [ADDR_W-1:0]       sys_addr,
    input  logic                    rng_chk_off,
    input  logic [RNG_W-1:0]        rng_base,
    input  logic [RNG_W-1:0]        rng_limit,
    input  logic [CHAN_W-1:0]       chan_sel,
    input  logic [CHANS-1:0]        ilv_mask,
    input  logic                    mode_hi,
    input  logic [1:0]              mode_lo,
    input  logic                    hole_vld,
    input  logic [HOLE_W-1:0]       hole_base,
    input  logic                    hole_remap,
    input  logic [HOFS_W-1:0]       hole_ofs,
    input  logic                    hoff_en,
    input  logic [CHANS*HOFF_W-1:0] hoff_flat,
    output logic                    out_valid,
    output logic                    out_err,
    output logic [1:0]              out_code,
    output logic [CHAN_W-1:0]       out_chan,
    output logic [ADDR_W-1:0]       out_addr
);
    ways_e             ways;
    logic              cfg_err, mode_err, on9, range_err, hole_err;
    logic [CHAN_W-1:0] chan;
    logic [ADDR_W-1:0] norm;
    route_t            nxt, cur;

    dcr_chan_pick u_pick (
        .addr(sys_addr), .mask(ilv_mask), .mode({mode_hi, mode_lo}),
        .fixed_sel(chan_sel), .ways(ways), .cfg_err(cfg_err),
        .mode_err(mode_err), .on9(on9), .chan(chan)
    );

    dcr_addr_norm u_norm (
        .addr(sys_addr), .chk_off(rng_chk_off), .base_f(rng_base),
        .limit_f(rng_limit), .hole_vld(hole_vld), .hole_base(hole_base),
        .hole_remap(hole_remap), .hole_ofs(hole_ofs), .hoff_en(hoff_en),
        .hoff_flat(hoff_flat), .chan(chan), .ways(ways), .on9(on9),
        .range_err(range_err), .hole_err(hole_err), .norm(norm)
    );

    always_comb begin
        nxt = '0;
        if (range_err)     begin nxt.err = 1'b1; nxt.code = ERR_RANGE; end
        else if (hole_err) begin nxt.err = 1'b1; nxt.code = ERR_HOLE;  end
        else if (cfg_err)  begin nxt.err = 1'b1; nxt.code = ERR_CFG;   end
        else if (mode_err) begin nxt.err = 1'b1; nxt.code = ERR_MODE;  end
        else begin
            nxt.chan = chan;
            nxt.addr = norm;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            cur       <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) cur <= nxt;
        end
    end

    assign out_err  = cur.err;
    assign out_code = cur.code;
    assign out_chan = cur.chan;
    assign out_addr = cur.addr;

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R1
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R3
    hole_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && rng_chk_off && hole_vld && sys_addr[ADDR_W-1:LOW4G_W] == '0 &&
         sys_addr[LOW4G_W-1:HOLE_SH] >= hole_base) |=> (out_err && out_code == 2'd1));
    // R4
    odd_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && rng_chk_off && !hole_vld && $countones(ilv_mask) == 1)
        |=> (out_err && out_code == 2'd2));
    // R6
    err_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_err) |-> (out_chan == '0 && out_addr == '0));
    // R7
    fixed_chan_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && rng_chk_off && !hole_vld && ilv_mask == '0)
        |=> (!out_err && out_chan == $past(chan_sel)));
    // R8
    two_way_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && $countones(ilv_mask) == 2)
        |=> (out_err || out_chan == 3'd0 || out_chan == 3'd3));
endmodule

// File: tb/dram_chan_router_tb.sv
`timescale 1ns/1ps
module dram_chan_router_tb_top;
    localparam longint unsigned M48 = 64'h0000_FFFF_FFFF_FFFF;
    localparam int WD_CYC = 150000;

    logic        clk = 0;
    logic        rst = 1;
    logic        in_valid = 0;
    logic [47:0] sys_addr = '0;
    logic        rng_chk_off = 0;
    logic [12:0] rng_base = '0, rng_limit = '0;
    logic [2:0]  chan_sel = '0;
    logic [3:0]  ilv_mask = '0;
    logic        mode_hi = 0;
    logic [1:0]  mode_lo = '0;
    logic        hole_vld = 0;
    logic [7:0]  hole_base = '0;
    logic        hole_remap = 0;
    logic [15:0] hole_ofs = '0;
    logic        hoff_en = 0;
    logic [47:0] hoff_flat = '0;
    logic        out_valid, out_err;
    logic [1:0]  out_code;
    logic [2:0]  out_chan;
    logic [47:0] out_addr;

    int    n_chk = 0, n_bad = 0;
    bit    done = 0;
    string drv_tag = "";

    always #10 clk = ~clk;

    dram_chan_router dut_i (.*);

    // Behavioural reference, written from the requirement list.
    function automatic void ref_model(
        output bit e, output int code, output int ch, output longint unsigned na,
        output int ways);
        longint unsigned a, lo, hi, ofs, p_keep, p_all;
        int m, sh;
        a  = longint'(sys_addr);
        lo = longint'(rng_base) * (64'd1 << 27);
        hi = longint'(rng_limit) * (64'd1 << 27) + (64'd1 << 27) - 1;
        ways = $countones(ilv_mask);
        m  = {mode_hi, mode_lo};
        sh = (m == 5) ? 9 : 8;
        e = 0; code = 0; ch = 0; na = 0;
        if (!rng_chk_off && (a < lo || a > hi)) begin e = 1; code = 0; end
        else if (hole_vld && a < 64'h1_0000_0000 &&
                 a >= longint'(hole_base) * 64'h100_0000) begin e = 1; code = 1; end
        else if (ways % 2 == 1) begin e = 1; code = 2; end
        else if (ways != 0 && m != 4 && m != 5) begin e = 1; code = 3; end
        if (e) return;
        if (ways == 0) ch = int'(chan_sel);
        else if (ways == 2) ch = ((a >> sh) % 2 == 1) ? 3 : 0;
        else ch = int'((a >> sh) % 4);
        ofs = (hole_remap && a >= 64'h1_0000_0000) ? longint'(hole_ofs) * 64'h100_0000 : lo;
        na  = (a - ofs) & M48;
        if (ways != 0) begin
            p_keep = 64'd1 << sh;
            p_all  = p_keep * ((ways == 2) ? 2 : 4);
            na = (na / p_all) * p_keep + na % p_keep;
        end
        if (hoff_en)
            na = (na + longint'((hoff_flat >> (12 * (ch % 4))) & 48'hFFF) * (64'd1 << 27)) & M48;
    endfunction

    bit              s_rst, s_v, e_err;
    int              e_code, e_ch, e_ways;
    longint unsigned e_addr;
    string           tag;

    always @(posedge clk) begin
        s_rst = rst;
        s_v   = in_valid;
        ref_model(e_err, e_code, e_ch, e_addr, e_ways);
        if (s_rst || !s_v) tag = "R1";
        else if (drv_tag != "") tag = drv_tag;
        else if (e_err) tag = (e_code == 0) ? "R2" : (e_code == 1) ? "R3" : (e_code == 2) ? "R4" : "R5";
        else if (hoff_en) tag = "R12";
        else tag = (e_ways == 0) ? "R7" : (e_ways == 2) ? "R8" : "R9";
        #5;
        if (!done) begin
            n_chk++;
            if (s_rst || !s_v) begin
                if (out_valid !== 1'b0 || (s_rst && out_err !== 1'b0)) begin
                    n_bad++;
                    $display("FAIL %s: valid=%0b err=%0b expected valid=0 err=0", tag, out_valid, out_err);
                end
            end else if (out_valid !== 1'b1 || out_err !== e_err ||
                         (e_err && out_code !== 2'(e_code)) ||
                         out_chan !== 3'(e_ch) || out_addr !== 48'(e_addr)) begin
                n_bad++;
                $display("FAIL %s: v=%0b err=%0b code=%0d ch=%0d addr=%h expected v=1 err=%0b code=%0d ch=%0d addr=%h",
                         tag, out_valid, out_err, out_code, out_chan, out_addr, e_err, e_code, e_ch, e_addr[47:0]);
            end
        end
    end

    task automatic go(input string t);
        drv_tag  = t;
        in_valid = 1;
        @(negedge clk);
    endtask

    task automatic base_cfg();
        rng_chk_off = 0; rng_base = 13'd0; rng_limit = 13'h1FFF;
        chan_sel = 3'd0; ilv_mask = 4'h0; {mode_hi, mode_lo} = 3'd4;
        hole_vld = 0; hole_base = 8'hC0; hole_remap = 0; hole_ofs = '0;
        hoff_en = 0; hoff_flat = 48'h123_456_789_ABC;
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        base_cfg();
        repeat (3) @(negedge clk);
        rst = 0;
        // R7 fixed channel
        sys_addr = 48'h0000_1234_5678; chan_sel = 3'd5; go("R7");
        // R8 two-way, bit 8 and bit 9 modes
        ilv_mask = 4'b1001; sys_addr = 48'h0000_0000_0100; go("R8");
        sys_addr = 48'h0000_0000_0200; go("R8");
        {mode_hi, mode_lo} = 3'd5; go("R8");
        // R9 four-way
        ilv_mask = 4'hF; sys_addr = 48'h0000_0000_0600; go("R9");
        {mode_hi, mode_lo} = 3'd4; go("R9");
        // R11 squeeze with ones above and below select bits
        sys_addr = 48'h0000_FFFF_FFFF; go("R11");
        ilv_mask = 4'b0101; {mode_hi, mode_lo} = 3'd5; go("R11");
        // R5 bad mode
        {mode_hi, mode_lo} = 3'd1; go("R5");
        // R4 odd mask
        ilv_mask = 4'b0111; go("R4");
        // R2 range boundaries
        base_cfg(); rng_base = 13'd2; rng_limit = 13'd3;
        sys_addr = 48'h0000_0FFF_FFFF; go("R2");
        sys_addr = 48'h0000_1000_0000; go("R2");
        sys_addr = 48'h0000_1FFF_FFFF; go("R2");
        sys_addr = 48'h0000_2000_0000; go("R2");
        rng_chk_off = 1; go("R2");
        // R3 hole edges
        hole_vld = 1; sys_addr = 48'h0000_BFFF_FFFF; go("R3");
        sys_addr = 48'h0000_C000_0000; go("R3");
        sys_addr = 48'h0001_0000_0000; go("R3");
        // R6 range and hole together; hole and odd mask together
        rng_chk_off = 0; rng_base = 13'd30; rng_limit = 13'd40; sys_addr = 48'h0000_D000_0000; go("R6");
        rng_chk_off = 1; ilv_mask = 4'b0001; go("R6");
        // R10 hoisted offset above 4 GB vs base offset below
        base_cfg(); rng_base = 13'd1; hole_remap = 1; hole_ofs = 16'h0040;
        sys_addr = 48'h0001_2345_6789; go("R10");
        sys_addr = 48'h0000_9345_6789; go("R10");
        // R12 high offset per channel
        hoff_en = 1; ilv_mask = 4'hF; sys_addr = 48'h0000_8000_0300; go("R12");
        sys_addr = 48'h0000_8000_0100; go("R12");
        // R1 gap in valid
        in_valid = 0; drv_tag = ""; @(negedge clk); @(negedge clk);
        for (int i = 0; i < 3000; i++) begin
            rng_chk_off = ($urandom % 2) == 0;
            rng_base    = 13'($urandom % 8);
            rng_limit   = 13'(rng_base + $urandom % 64);
            chan_sel    = 3'($urandom);
            case ($urandom % 6)
                0: ilv_mask = 4'h0;
                1: ilv_mask = 4'b1001;
                2: ilv_mask = 4'hF;
                3: ilv_mask = 4'b0110;
                default: ilv_mask = 4'($urandom);
            endcase
            {mode_hi, mode_lo} = ($urandom % 4 == 0) ? 3'($urandom) : (($urandom % 2 == 1) ? 3'd5 : 3'd4);
            hole_vld   = ($urandom % 3) == 0;
            hole_base  = 8'($urandom % 256);
            hole_remap = $urandom % 2 == 1;
            hole_ofs   = 16'($urandom % 4096);
            hoff_en    = $urandom % 2 == 1;
            hoff_flat  = {16'($urandom), 32'($urandom)};
            sys_addr   = {16'($urandom % 4), 32'($urandom)};
            if ($urandom % 5 == 0) begin
                in_valid = 0; drv_tag = ""; @(negedge clk);
            end else go("");
        end
        in_valid = 0; drv_tag = "";
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule